// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog countdown timer that sits in the system clock domain. It advances on a slow tick enable, which stands in for a low-speed oscillator. Software controls it through a small register port with four registers: a key register, a divider-select register, a reload register and a status register. Writing particular 16-bit values to the key register does three things. One value opens the configuration registers for writing. One reloads the counter, which is the refresh. One starts the timer.

A power-of-two prescaler feeds a 12-bit down-counter. When the counter runs out, the block raises a one-cycle reset request and reloads itself. A new divider or reload setting does not take effect at once. It stays pending for a fixed number of slow ticks, and the matching status bit shows busy for that time. Once the timer is started, nothing stops it short of a reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the divider field reads 0, the reload value reads 0xFFF, the status reads 0, `cnt_value` is 0xFFF and `rst_req` is low. The block is locked and stopped.
- R2: Register addresses are: 0 for the key register, which always reads 0; 1 for the divider field in bits [2:0]; 2 for the reload value in bits [11:0]; 3 for status, with bit 0 = divider busy and bit 1 = reload busy. The key codes are 0x5555 to unlock, 0xAAAA to refresh and 0xCCCC to start.
- R3: Writes to addresses 1 and 2 are ignored while the block is locked. Writing 0x5555 to the key register unlocks it. Writing any other value to the key register locks it again, and that includes 0xAAAA and 0xCCCC.
- R4: An accepted write to address 1 or 2 sets the matching busy bit for exactly 5 slow ticks. Until then, reads of that register return the old value. On the 5th tick the new value takes effect and the busy bit clears.
- R5: A write to a register whose busy bit is set is ignored.
- R6: A refresh loads the counter from the active reload value and restarts the prescaler phase. This also works while the timer is stopped.
- R7: While the timer is stopped, the counter and the prescaler do not move and `rst_req` stays low.
- R8: The divide ratio is 4 shifted left by the divider field. Field values 6 and 7 both give 256. The counter steps once for every ratio slow ticks.
- R9: A prescaled step taken while the counter is at zero gives a one-cycle `rst_req` pulse and reloads the counter. The first request therefore comes (reload+1)×ratio slow ticks after a refresh, and the requests then repeat with that same period.
- R10: Once started, the timer keeps running whatever key values are written later.
- R11: Refreshing more often than the timeout period prevents any reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow oscillator period |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational on bus_addr) |
| rst_req | output | 1 | One-cycle reset request on expiry |
| cnt_value | output | 12 | Current down-counter value |

## Verification
The assertions assume that `slow_tick` is a single-cycle pulse and that bus writes are single-cycle strobes. They also assume software never expects a write made during busy or while locked to land anywhere. Within those assumptions they check four things: the request pulse lasts one cycle and comes from an empty counter; the started state is sticky; a stopped counter holds its value; a locked write never raises a busy bit. The stimulus drives every bus access with `slow_tick` held low, and it spaces ticks at least one idle cycle apart, so a tick never lands in the same cycle as a key write.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CNT_W      = 12,
  parameter int SEL_W      = 3,
  parameter int SEL_MAX    = 6,
  parameter int DATA_W     = 16,
  parameter int BUSY_TICKS = 5,
  parameter logic [15:0] KEY_OPEN = 16'h5555,
  parameter logic [15:0] KEY_KICK = 16'hAAAA,
  parameter logic [15:0] KEY_GO   = 16'hCCCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic [CNT_W-1:0]  cnt_value
);
  localparam int PH_W = 2 + SEL_MAX;
  localparam int BW   = $clog2(BUSY_TICKS + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_TICKS);

  logic              unlocked, running;
  logic [SEL_W-1:0]  sel_act, sel_new;
  logic [CNT_W-1:0]  rl_act, rl_new, cnt;
  logic [BW-1:0]     sel_busy, rl_busy;
  logic [PH_W-1:0]   phase;

  wire wr     = bus_valid & bus_write;
  wire key_wr = wr && bus_addr == 2'd0;
  wire kick   = key_wr && bus_wdata[15:0] == KEY_KICK;
  wire go     = key_wr && bus_wdata[15:0] == KEY_GO;
  wire open_k = key_wr && bus_wdata[15:0] == KEY_OPEN;
  wire sel_wr = wr && bus_addr == 2'd1 && unlocked && sel_busy == '0;
  wire rl_wr  = wr && bus_addr == 2'd2 && unlocked && rl_busy == '0;

  wire [SEL_W-1:0] sel_eff = (sel_act > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_act;
  wire [PH_W:0]    ratio   = (PH_W+1)'(4) << sel_eff;
  wire [PH_W-1:0]  lim     = PH_W'(ratio - 1'b1);
  wire             step    = slow_tick && running && phase == lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (key_wr) unlocked <= open_k;
      if (go)     running  <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_busy <= '0;
      sel_new  <= '0;
      sel_act  <= '0;
    end else if (sel_wr) begin
      sel_busy <= BUSY_LOAD;
      sel_new  <= bus_wdata[SEL_W-1:0];
    end else if (slow_tick && sel_busy != '0) begin
      sel_busy <= sel_busy - 1'b1;
      if (sel_busy == BW'(1)) sel_act <= sel_new;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rl_busy <= '0;
      rl_new  <= '1;
      rl_act  <= '1;
    end else if (rl_wr) begin
      rl_busy <= BUSY_LOAD;
      rl_new  <= bus_wdata[CNT_W-1:0];
    end else if (slow_tick && rl_busy != '0) begin
      rl_busy <= rl_busy - 1'b1;
      if (rl_busy == BW'(1)) rl_act <= rl_new;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= '0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (kick) begin
        phase <= '0;
        cnt   <= rl_act;
      end else if (slow_tick && running) begin
        phase <= step ? '0 : phase + 1'b1;
        if (step) begin
          if (cnt == '0) begin
            cnt     <= rl_act;
            rst_req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end

  assign cnt_value = cnt;

  always_comb
    case (bus_addr)
      2'd1:    bus_rdata = DATA_W'(sel_act);
      2'd2:    bus_rdata = DATA_W'(rl_act);
      2'd3:    bus_rdata = DATA_W'({rl_busy != '0, sel_busy != '0});
      default: bus_rdata = '0;
    endcase
endmodule

module keyed_wdog_chk #(
  parameter int CNT_W = 12,
  parameter int BW    = 3,
  parameter int BUSY_TICKS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             running,
  input logic             kick,
  input logic             unlocked,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_addr,
  input logic [BW-1:0]    sel_busy,
  input logic [BW-1:0]    rl_busy,
  input logic [CNT_W-1:0] cnt
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_REQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(cnt) == '0); // R9
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R10
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !kick) |=> $stable(cnt)); // R7
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req); // R7
  AST_LOCKED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 2'd1 && !unlocked && sel_busy == '0) |=> sel_busy == '0); // R3
  AST_LOCKED_RL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 2'd2 && !unlocked && rl_busy == '0) |=> rl_busy == '0); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_busy <= BW'(BUSY_TICKS) && rl_busy <= BW'(BUSY_TICKS)); // R4
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W), .BW(BW), .BUSY_TICKS(BUSY_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .running(running), .kick(kick),
  .unlocked(unlocked), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .sel_busy(sel_busy), .rl_busy(rl_busy), .cnt(cnt)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int CLK_HALF = 5;
  localparam int MAXT = 3000;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic rst_req;
  logic [11:0] cnt_value;
  int total = 0, bad = 0;
  logic [15:0] rd;
  int n;

  keyed_wdog u0 (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .cnt_value(cnt_value));

  always #CLK_HALF clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(output bit req);
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    req = rst_req;
  endtask

  task automatic ticks(input int k, output int reqs);
    bit r;
    reqs = 0;
    for (int i = 0; i < k; i++) begin tick(r); if (r) reqs++; end
  endtask

  task automatic until_req(output int cntk);
    bit r;
    cntk = 0;
    for (int i = 0; i < MAXT; i++) begin
      tick(r); cntk++;
      if (r) return;
    end
    cntk = -1;
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 reset state
    bread(2'd1, rd); chk(rd == 0, "R1 divider reset", rd, 0);
    bread(2'd2, rd); chk(rd == 16'hFFF, "R1 reload reset", rd, 16'hFFF);
    bread(2'd3, rd); chk(rd == 0, "R1 status reset", rd, 0);
    bread(2'd0, rd); chk(rd == 0, "R2 key reads zero", rd, 0);
    chk(cnt_value == 12'hFFF, "R1 counter reset", cnt_value, 12'hFFF);
    chk(rst_req == 0, "R1 req low", rst_req, 0);
    // R3 locked writes ignored
    bwrite(2'd2, 16'd3);
    bread(2'd3, rd); chk(rd == 0, "R3 locked write no busy", rd, 0);
    ticks(6, r0);
    bread(2'd2, rd); chk(rd == 16'hFFF, "R3 locked write ignored", rd, 16'hFFF);
    // R3 relock on other key value
    bwrite(2'd0, 16'h5555);
    bwrite(2'd0, 16'h1234);
    bwrite(2'd1, 16'd2);
    bread(2'd3, rd); chk(rd == 0, "R3 relock after other key", rd, 0);
    // R4 R5 busy timing and write-during-busy
    bwrite(2'd0, 16'h5555);
    bwrite(2'd2, 16'd3);
    bwrite(2'd2, 16'd9);
    bread(2'd3, rd); chk(rd == 2, "R4 reload busy set", rd, 2);
    ticks(4, r0);
    bread(2'd3, rd); chk(rd == 2, "R4 busy after 4 ticks", rd, 2);
    bread(2'd2, rd); chk(rd == 16'hFFF, "R4 old value while busy", rd, 16'hFFF);
    ticks(1, r0);
    bread(2'd3, rd); chk(rd == 0, "R4 busy clear after 5 ticks", rd, 0);
    bread(2'd2, rd); chk(rd == 3, "R5 write during busy ignored", rd, 3);
    // R7 stopped counter frozen
    chk(cnt_value == 12'hFFF && r0 == 0, "R7 stopped frozen", cnt_value, 12'hFFF);
    // R6 refresh while stopped
    bwrite(2'd0, 16'hAAAA);
    chk(cnt_value == 3, "R6 refresh loads reload", cnt_value, 3);
    ticks(20, r0);
    chk(cnt_value == 3 && r0 == 0, "R7 no count before start", cnt_value, 3);
    // R10 start, R9 first period
    bwrite(2'd0, 16'hCCCC);
    until_req(n); chk(n == 16, "R9 period div0 rl3", n, 16);
    bwrite(2'd0, 16'h0000);
    bwrite(2'd0, 16'h5555);
    until_req(n); chk(n == 16, "R10 still running after keys", n, 16);
    // R11 frequent refresh
    r0 = 0;
    for (int k = 0; k < 8; k++) begin
      int q;
      bwrite(2'd0, 16'hAAAA);
      ticks(12, q); r0 += q;
    end
    chk(r0 == 0, "R11 refresh prevents request", r0, 0);
    // R8 R9 sweep over divider field and small reload values
    for (int s = 0; s < 8; s++) begin
      for (int rl = 0; rl < 4; rl += 2) begin
        int ratio, q;
        ratio = (s >= 6) ? 256 : (4 << s);
        bwrite(2'd0, 16'h5555);
        bwrite(2'd1, 16'(s));
        bwrite(2'd2, 16'(rl));
        ticks(5, q);
        bread(2'd1, rd); chk(rd == s, "R4 divider applied", rd, s);
        bwrite(2'd0, 16'hAAAA);
        chk(cnt_value == rl, "R6 refresh value", cnt_value, rl);
        if (rl == 2) begin
          ticks(ratio, q);
          chk(cnt_value == rl - 1, "R8 one step per ratio ticks", cnt_value, rl - 1);
          until_req(n);
          chk(n == rl * ratio, "R9 remaining ticks", n, rl * ratio);
        end else begin
          until_req(n);
          chk(n == (rl + 1) * ratio, "R8 R9 timeout ticks", n, (rl + 1) * ratio);
        end
        @(negedge clk);
        chk(rst_req == 0, "R9 one-cycle pulse", rst_req, 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule